// File: doc/BRIEF.md
# Restartable Sequential Integer Divider

This block is a memory-mapped integer divider for a processor subsystem. Software writes a dividend and a divisor through a small register bus. Every operand write launches a fresh iterative division, and the quotient and remainder become readable once the status word reports the unit idle. Two address aliases per operand select unsigned or signed (two's complement) interpretation. The alias used for the most recent operand write decides the mode of the division it starts.

The unit supports cheap context switching. A new operand write abandons any division in flight and begins again. A write to a result register cancels the running division and stores the written value, so saved results can be put back. A dirty flag records that the unit has been touched since the quotient was last read. A save routine can skip the unit when the flag is clear. It should read the remainder before the quotient, because the quotient read clears the flag.

The register bus is a plain strobe interface: one access per cycle, write data taken at the clock edge, read data returned combinationally in the same cycle. It has no valid/ready handshake because the unit never stalls an access. A caller that needs the result polls the status word.

Top module: `seqdiv_unit`

## Requirements
- R1: After reset the status word reads 1 (idle, not dirty) and both the quotient and the remainder read 0.
- R2: A write to any operand address starts a division. The status ready bit reads 0 for exactly WIDTH/DIGIT_BITS cycles (8 with defaults) after the write edge, then reads 1 with the results loaded.
- R3: An operand write during a running division restarts it. The results belong to the latest operands and arrive the full latency after that last write.
- R4: A write to the quotient or remainder address stops any running division. In the next cycle ready=1, dirty=1 and the written value reads back. The cancelled division never updates either result register.
- R5: Any register write sets the dirty bit. A read of the quotient address clears it. A read of the remainder or status address leaves it unchanged.
- R6: Address map on `bus_addr`: 0 unsigned dividend, 1 unsigned divisor, 2 signed dividend, 3 signed divisor, 4 quotient, 5 remainder, 6 status. Operand addresses read back the stored operand. Status bit 0 is ready, bit 1 is dirty, and all other bits read 0.
- R7: In unsigned mode the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor, across the full WIDTH-bit range.
- R8: In signed mode the quotient truncates toward zero and the remainder has the sign of the dividend. The most negative value divided by -1 gives the most negative value as quotient and 0 as remainder.
- R9: With a zero divisor the remainder equals the dividend. The quotient is all ones, except in signed mode with a negative dividend, where it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, data taken at the clock edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe, has side effects (dirty clear) |
| bus_rdata | output | WIDTH | Read data for the addressed register, same cycle |

## Verification
The bench builds the unit with WIDTH=32 and DIGIT_BITS=4, so each division takes eight iteration cycles. With these values the exact ready-low window can be counted by polling. They also make the full 32-bit extremes reachable: all-ones divided by one, the most negative value divided by -1, and zero divisors in both modes. Restart and cancel are issued a few cycles into the eight-cycle window, so a division that leaks through would overwrite a result the bench has already predicted.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_UDIVIDEND = 3'd0,
    A_UDIVISOR  = 3'd1,
    A_SDIVIDEND = 3'd2,
    A_SDIVISOR  = 3'd3,
    A_QUOT      = 3'd4,
    A_REM       = 3'd5,
    A_STATUS    = 3'd6
  } reg_addr_e;

  localparam int ST_READY = 0;
  localparam int ST_DIRTY = 1;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  input  logic             sgn,
  output logic [WIDTH-1:0] mag_num,
  output logic [WIDTH-1:0] mag_den,
  output logic             neg_quo,
  output logic             neg_rem
);
  logic neg_n, neg_d;

  assign neg_n   = sgn & num[WIDTH-1];
  assign neg_d   = sgn & den[WIDTH-1];
  assign mag_num = neg_n ? -num : num;
  assign mag_den = neg_d ? -den : den;
  assign neg_quo = neg_n ^ neg_d;
  assign neg_rem = neg_n;
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] q_raw,
  input  logic [WIDTH-1:0] r_raw,
  input  logic             neg_quo,
  input  logic             neg_rem,
  output logic [WIDTH-1:0] q_out,
  output logic [WIDTH-1:0] r_out
);
  assign q_out = neg_quo ? -q_raw : q_raw;
  assign r_out = neg_rem ? -r_raw : r_raw;
endmodule

// File: rtl/div_iter.sv
module div_iter #(
  parameter int WIDTH      = 32,
  parameter int DIGIT_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  output logic             busy,
  output logic             fin,
  output logic [WIDTH-1:0] q_next,
  output logic [WIDTH-1:0] r_next
);
  localparam int STEPS = WIDTH / DIGIT_BITS;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] num_q, den_q, quo_q, rem_q;

  // One digit per cycle: DIGIT_BITS restoring steps chained combinationally
  always_comb begin
    logic [WIDTH:0]   t;
    logic [WIDTH-1:0] r_w, n_w, q_w;
    r_w = rem_q;
    n_w = num_q;
    q_w = quo_q;
    for (int i = 0; i < DIGIT_BITS; i++) begin
      t   = {r_w, n_w[WIDTH-1]};
      n_w = n_w << 1;
      if (t >= {1'b0, den_q}) begin
        t   = t - {1'b0, den_q};
        q_w = {q_w[WIDTH-2:0], 1'b1};
      end else begin
        q_w = {q_w[WIDTH-2:0], 1'b0};
      end
      r_w = t[WIDTH-1:0];
    end
    q_next = q_w;
    r_next = r_w;
    step_num = n_w;
  end

  logic [WIDTH-1:0] step_num;

  assign busy = busy_q;
  assign fin  = busy_q && (cnt_q == CNT_W'(1)) && !start && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(STEPS);
      num_q  <= num;
      den_q  <= den;
      quo_q  <= '0;
      rem_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      num_q  <= step_num;
      quo_q  <= q_next;
      rem_q  <= r_next;
      cnt_q  <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  p_fin_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy_q);
  p_cnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));
  p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !busy_q);
endmodule

// File: rtl/seqdiv_unit.sv
module seqdiv_unit
  import seqdiv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int DIGIT_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata
);
  logic [WIDTH-1:0] dvd_q, dvs_q, quo_q, rem_q;
  logic             sgn_q, negq_q, negr_q, dirty_q;
  logic [WIDTH-1:0] dvd_n, dvs_n;
  logic             sgn_n;
  logic             wr_dvd, wr_dvs, op_wr, res_wr, wr_quo, wr_rem;
  logic [WIDTH-1:0] mag_num, mag_den, q_nx, r_nx, q_fx, r_fx;
  logic             neg_quo, neg_rem, core_busy, core_fin, ready;

  assign wr_dvd = bus_wr && (bus_addr == A_UDIVIDEND || bus_addr == A_SDIVIDEND);
  assign wr_dvs = bus_wr && (bus_addr == A_UDIVISOR  || bus_addr == A_SDIVISOR);
  assign wr_quo = bus_wr && (bus_addr == A_QUOT);
  assign wr_rem = bus_wr && (bus_addr == A_REM);
  assign op_wr  = wr_dvd || wr_dvs;
  assign res_wr = wr_quo || wr_rem;

  // Operands as they will be after this edge, so a start uses the fresh value
  assign dvd_n = wr_dvd ? bus_wdata : dvd_q;
  assign dvs_n = wr_dvs ? bus_wdata : dvs_q;
  assign sgn_n = op_wr ? (bus_addr == A_SDIVIDEND || bus_addr == A_SDIVISOR) : sgn_q;

  div_prep #(.WIDTH(WIDTH)) u_prep (
    .num(dvd_n), .den(dvs_n), .sgn(sgn_n),
    .mag_num(mag_num), .mag_den(mag_den),
    .neg_quo(neg_quo), .neg_rem(neg_rem)
  );

  div_iter #(.WIDTH(WIDTH), .DIGIT_BITS(DIGIT_BITS)) u_iter (
    .clk(clk), .rst_n(rst_n), .start(op_wr), .abort(res_wr),
    .num(mag_num), .den(mag_den),
    .busy(core_busy), .fin(core_fin), .q_next(q_nx), .r_next(r_nx)
  );

  div_fix #(.WIDTH(WIDTH)) u_fix (
    .q_raw(q_nx), .r_raw(r_nx), .neg_quo(negq_q), .neg_rem(negr_q),
    .q_out(q_fx), .r_out(r_fx)
  );

  assign ready = !core_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q   <= '0;
      dvs_q   <= '0;
      sgn_q   <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      dvd_q <= dvd_n;
      dvs_q <= dvs_n;
      sgn_q <= sgn_n;
      if (op_wr) begin
        negq_q <= neg_quo;
        negr_q <= neg_rem;
      end
      if (wr_quo)        quo_q <= bus_wdata;
      else if (core_fin) quo_q <= q_fx;
      if (wr_rem)        rem_q <= bus_wdata;
      else if (core_fin) rem_q <= r_fx;
      if (bus_wr)                              dirty_q <= 1'b1;
      else if (bus_rd && bus_addr == A_QUOT)   dirty_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_UDIVIDEND, A_SDIVIDEND: bus_rdata = dvd_q;
      A_UDIVISOR,  A_SDIVISOR:  bus_rdata = dvs_q;
      A_QUOT:                   bus_rdata = quo_q;
      A_REM:                    bus_rdata = rem_q;
      A_STATUS: begin
        bus_rdata[ST_READY] = ready;
        bus_rdata[ST_DIRTY] = dirty_q;
      end
      default:                  bus_rdata = '0;
    endcase
  end

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> !ready);
  p_reswr_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> (ready && dirty_q));
  p_abort_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_quo) |=> $stable(quo_q));
  p_dirty_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> dirty_q);
  p_dirty_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_QUOT && !bus_wr) |=> !dirty_q);
endmodule

// File: tb/sim_seqdiv_unit.sv
module sim_seqdiv_unit;
  import seqdiv_pkg::*;
  localparam int W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic [W-1:0]     bus_wdata = '0;
  logic             bus_rd = 1'b0;
  logic [W-1:0]     bus_rdata;

  int n_chk = 0, n_fail = 0;
  int m_chk = 0, m_fail = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_r[$];
  string        exp_tag[$];

  always #2 clk = ~clk;

  seqdiv_unit #(.WIDTH(W), .DIGIT_BITS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [W-1:0] d);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(output int lows);
    logic [W-1:0] s;
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      bus_read(A_STATUS, s);
      if (s[ST_READY]) break;
      lows++;
    end
  endtask

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                       output logic [W-1:0] q, output logic [W-1:0] r);
    if (b == '0) begin
      r = a;
      q = (sgn && a[W-1]) ? 32'd1 : '1;
    end else if (!sgn) begin
      q = a / b;
      r = a % b;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = a;
      r = '0;
    end else begin
      q = $signed(a) / $signed(b);
      r = $signed(a) % $signed(b);
    end
  endtask

  // Driver: issue operands, predict, wait, then read remainder and quotient
  task automatic do_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                        input string tag, output int lows);
    logic [W-1:0] q, r, d;
    bus_write(sgn ? A_SDIVIDEND : A_UDIVIDEND, a);
    bus_write(sgn ? A_SDIVISOR  : A_UDIVISOR,  b);
    model(a, b, sgn, q, r);
    exp_q.push_back(q); exp_r.push_back(r); exp_tag.push_back(tag);
    wait_ready(lows);
    bus_read(A_REM, d);
    bus_read(A_QUOT, d);
  endtask

  // Monitor: compares result reads against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_rd && exp_q.size() > 0) begin
        if (bus_addr == A_REM) begin
          m_chk++;
          if (bus_rdata !== exp_r[0]) begin
            m_fail++;
            $display("FAIL %s remainder: got %h expected %h", exp_tag[0], bus_rdata, exp_r[0]);
          end
        end else if (bus_addr == A_QUOT) begin
          m_chk++;
          if (bus_rdata !== exp_q[0]) begin
            m_fail++;
            $display("FAIL %s quotient: got %h expected %h", exp_tag[0], bus_rdata, exp_q[0]);
          end
          void'(exp_q.pop_front()); void'(exp_r.pop_front()); void'(exp_tag.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk + 1, n_fail + m_fail + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] d, q, r;
    int lows;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    bus_read(A_STATUS, d); chk("R1 status", d, 32'd1);
    bus_read(A_QUOT, d);   chk("R1 quotient", d, 32'd0);
    bus_read(A_REM, d);    chk("R1 remainder", d, 32'd0);

    do_div(32'd100, 32'd7, 1'b0, "R7 100/7", lows);
    chk("R2 ready-low cycles", 32'(lows), 32'd8);
    do_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R7 max/1", lows);
    do_div(32'd5, 32'd10, 1'b0, "R7 5/10", lows);
    do_div(32'hDEAD_BEEF, 32'h0000_1234, 1'b0, "R7 big", lows);
    do_div(32'hFFFF_FFF9, 32'd2, 1'b1, "R8 -7/2", lows);
    do_div(32'd7, 32'hFFFF_FFFE, 1'b1, "R8 7/-2", lows);
    do_div(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, "R8 -7/-2", lows);
    do_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8 min/-1", lows);
    do_div(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b0, "R7 unsigned alias", lows);
    do_div(32'd123, 32'd0, 1'b0, "R9 unsigned /0", lows);
    do_div(32'hFFFF_FFFB, 32'd0, 1'b1, "R9 signed -5/0", lows);
    do_div(32'd5, 32'd0, 1'b1, "R9 signed 5/0", lows);
    bus_read(A_STATUS, d); chk("R5 quotient read clears dirty", d, 32'd1);

    // R5: dirty survives remainder and status reads
    bus_write(A_UDIVIDEND, 32'd77);
    bus_write(A_UDIVISOR, 32'd4);
    wait_ready(lows);
    bus_read(A_STATUS, d); chk("R5 dirty after write", d, 32'd3);
    bus_read(A_REM, d);    chk("R7 77%4", d, 32'd1);
    bus_read(A_STATUS, d); chk("R5 remainder read keeps dirty", d, 32'd3);
    bus_read(A_QUOT, d);   chk("R7 77/4", d, 32'd19);
    bus_read(A_STATUS, d); chk("R5 dirty cleared", d, 32'd1);

    // R6: operand read-back
    bus_read(A_UDIVIDEND, d); chk("R6 dividend readback", d, 32'd77);
    bus_read(A_SDIVISOR, d);  chk("R6 divisor alias readback", d, 32'd4);

    // R3: restart mid-calculation
    bus_write(A_UDIVIDEND, 32'd1000);
    bus_write(A_UDIVISOR, 32'd3);
    idle(3);
    bus_write(A_UDIVISOR, 32'd7);
    model(32'd1000, 32'd7, 1'b0, q, r);
    exp_q.push_back(q); exp_r.push_back(r); exp_tag.push_back("R3 restart");
    wait_ready(lows);
    chk("R3 full latency after restart", 32'(lows), 32'd8);
    bus_read(A_REM, d);
    bus_read(A_QUOT, d);

    // R4: result write cancels a running division
    bus_write(A_UDIVIDEND, 32'd50000);
    bus_write(A_UDIVISOR, 32'd9);
    idle(2);
    bus_write(A_QUOT, 32'h0000_1234);
    bus_read(A_STATUS, d); chk("R4 ready and dirty after result write", d, 32'd3);
    idle(12);
    bus_read(A_STATUS, d); chk("R4 still idle", d, 32'd3);
    bus_read(A_REM, d);    chk("R4 remainder untouched by cancelled run", d, 32'd6);
    bus_read(A_QUOT, d);   chk("R4 restored quotient", d, 32'h0000_1234);
    bus_write(A_REM, 32'h55);
    bus_read(A_STATUS, d); chk("R4 R5 remainder write sets dirty", d, 32'd3);
    bus_read(A_REM, d);    chk("R4 restored remainder", d, 32'h55);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk, n_fail + m_fail);
    $finish;
  end
endmodule